// File: doc/BRIEF.md
# External Memory Bus Select and Control-Register Glue

This block sits beside an asynchronous external memory bus and turns the raw bus strobes into device selects. Inside the first chip-enable space it separates a paged flash device from two serial-port channels and from a small block of control registers. For all three chip-enable spaces it drives the enable and the direction pin of the bidirectional data buffer that isolates the bus.

The register block holds three registers. A page register extends the flash address with extra high-order lines. A 6-bit display control register is readable and writable. An 8-bit register drives eight indicator LEDs. The bus master writes a register by asserting the write strobe and releasing it. The value is captured when the strobe rises, while the register region is still selected. A read returns the addressed register on a dedicated read-data output, and only during an active read strobe.

Top module: `membus_glue`

## Requirements
- R1: `flash_ce_n` is 0 exactly when `ce_n[0]` is 0 and `addr[22]` is 0; otherwise it is 1.
- R2: `uart_a_cs_n` is 0 exactly when `ce_n[0]`=0, `addr[22]`=1 and `addr[8:6]`=3'b000. `uart_b_cs_n` is 0 exactly when `ce_n[0]`=0, `addr[22]`=1 and `addr[8:6]`=3'b001. At most one of the flash and serial selects is low at any time.
- R3: `buf_oe_n` is 0 whenever any bit of `ce_n[2:0]` is 0, and 1 when all three bits are 1.
- R4: `buf_dir` is 1 exactly when any bit of `ce_n[2:0]` is 0 and `aoe_n` is 0; otherwise it is 0.
- R5: The register region is `ce_n[0]`=0, `addr[22]`=1 and `addr[8:6]`=3'b010. Inside it, `addr[2:0]` selects the register: 0 is display control, 1 is flash page, 2 is LEDs. A write takes effect on the first clock edge at which `awe_n` is seen high after having been low, provided the region is selected at that edge. Holding `awe_n` low changes nothing.
- R6: `flash_page[2:0]` follows the page register, which takes `wdata[2:0]`. It reads back with bits 7..3 as zero.
- R7: The display control register stores `wdata[5:0]` and reads back with bits 7..6 as zero.
- R8: `led[n]` equals bit n of the LED register for n = 0..7, and the register reads back as written.
- R9: `rdata` carries the addressed register only while the register region is selected and `are_n` is 0. At all other times it is 0. Register indices 3 to 7 read 0, and writes to them have no effect.
- R10: A synchronous active-high `rst` clears the display, page and LED registers.
- R11: A rising `awe_n` while the register region is not selected leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the strobes and updates the registers |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 3 | Active-low chip enables; bit 0 is the first space |
| addr | input | 23 | Bus address |
| aoe_n | input | 1 | Active-low bus output-enable strobe |
| are_n | input | 1 | Active-low read strobe |
| awe_n | input | 1 | Active-low write strobe |
| wdata | input | 8 | Write data from the bus |
| flash_ce_n | output | 1 | Active-low flash select |
| uart_a_cs_n | output | 1 | Active-low select for serial channel A |
| uart_b_cs_n | output | 1 | Active-low select for serial channel B |
| buf_oe_n | output | 1 | Active-low data-buffer enable |
| buf_dir | output | 1 | Data-buffer direction, 1 toward the bus master |
| flash_page | output | 3 | Extended flash page address lines |
| led | output | 8 | LED drives, bit n lights LED n+1 |
| rdata | output | 8 | Register read-back data, 0 when not reading |

## Verification
The write-capture assertions assume that `addr`, `wdata` and `ce_n[0]` are stable during the clock cycle in which `awe_n` rises. The bench holds all of them from the falling edge on which it lowers the strobe until one full cycle after it raises it. The select and buffer assertions place no demand on the inputs, so the bench sweeps every combination of chip enables, `addr[22]`, `addr[8:6]` and `aoe_n`. Reads never overlap a write, because the bench keeps `are_n` and `awe_n` from being low together.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned IDX_DISP = 0;
  localparam int unsigned IDX_PAGE = 1;
  localparam int unsigned IDX_LED  = 2;

  localparam logic [2:0] WIN_UART_A = 3'b000;
  localparam logic [2:0] WIN_UART_B = 3'b001;
  localparam logic [2:0] WIN_REGS   = 3'b010;

  typedef struct packed {
    logic flash;
    logic uart_a;
    logic uart_b;
    logic regs;
  } hit_t;

  function automatic hit_t space1_hits(input logic active, input logic hi_bit,
                                       input logic [2:0] win);
    hit_t h;
    h.flash  = active && !hi_bit;
    h.uart_a = active && hi_bit && (win == WIN_UART_A);
    h.uart_b = active && hi_bit && (win == WIN_UART_B);
    h.regs   = active && hi_bit && (win == WIN_REGS);
    return h;
  endfunction

  function automatic logic [7:0] zext_read(input logic [7:0] v, input int unsigned w);
    logic [7:0] m;
    m = 8'hFF >> (8 - w);
    return v & m;
  endfunction
endpackage

// File: rtl/cs_decode.sv
module cs_decode #(
  parameter int unsigned NUM_CE = 3,
  parameter int unsigned ADDR_W = 23
) (
  input  logic [NUM_CE-1:0] ce_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              aoe_n,
  output logic              flash_ce_n,
  output logic              uart_a_cs_n,
  output logic              uart_b_cs_n,
  output logic              reg_hit,
  output logic              buf_oe_n,
  output logic              buf_dir
);
  import glue_pkg::*;

  hit_t hits;
  logic any_space;

  always_comb begin
    hits        = space1_hits(!ce_n[0], addr[ADDR_W-1], addr[8:6]);
    any_space   = !(&ce_n);
    flash_ce_n  = !hits.flash;
    uart_a_cs_n = !hits.uart_a;
    uart_b_cs_n = !hits.uart_b;
    reg_hit     = hits.regs;
    buf_oe_n    = !any_space;
    buf_dir     = any_space && !aoe_n;
  end

  always_comb begin
    // R2: flash and serial selects never overlap
    assert_sel_exclusive_R2: assert ($onehot0({!flash_ce_n, !uart_a_cs_n, !uart_b_cs_n, reg_hit}));
    // R4: buffer only turns toward the master while it is enabled
    assert_dir_needs_oe_R4: assert (!buf_dir || !buf_oe_n);
  end
endmodule

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b1;
    else     strobe_q <= strobe_n;
  end

  assign rise = !strobe_q && strobe_n;

  // R5: a release is reported only after the strobe was seen low
  assert_rise_after_low_R5: assert property (@(posedge clk) disable iff (rst)
    rise |-> $past(!strobe_n));
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned DISP_W = 6,
  parameter int unsigned LED_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_pulse,
  input  logic                        reg_hit,
  input  logic [glue_pkg::IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        rd_en,
  output logic [PAGE_W-1:0]           page,
  output logic [LED_W-1:0]            led,
  output logic [DATA_W-1:0]           rdata
);
  import glue_pkg::*;

  localparam int unsigned NUM_REGS = 3;

  logic [DISP_W-1:0]   disp_q;
  logic [PAGE_W-1:0]   page_q;
  logic [LED_W-1:0]    led_q;
  logic [NUM_REGS-1:0] wr_sel;
  logic [DATA_W-1:0]   rd_mux;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
      assign wr_sel[i] = wr_pulse && reg_hit && (idx == i[IDX_W-1:0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_q <= '0;
      page_q <= '0;
      led_q  <= '0;
    end else begin
      if (wr_sel[IDX_DISP]) disp_q <= wdata[DISP_W-1:0];
      if (wr_sel[IDX_PAGE]) page_q <= wdata[PAGE_W-1:0];
      if (wr_sel[IDX_LED])  led_q  <= wdata[LED_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      IDX_W'(IDX_DISP): rd_mux = DATA_W'(disp_q);
      IDX_W'(IDX_PAGE): rd_mux = DATA_W'(page_q);
      IDX_W'(IDX_LED):  rd_mux = DATA_W'(led_q);
      default:          rd_mux = '0;
    endcase
    rdata = rd_en ? rd_mux : '0;
  end

  assign page = page_q;
  assign led  = led_q;

  // R10: registers are clear right after reset
  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (page == '0 && led == '0));
  // R8: an LED write lands one cycle after the strobe release
  assert_led_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_sel[IDX_LED] |=> led == $past(wdata[LED_W-1:0]));
  // R6: a page write lands one cycle after the strobe release
  assert_page_write_R6: assert property (@(posedge clk) disable iff (rst)
    wr_sel[IDX_PAGE] |=> page == $past(wdata[PAGE_W-1:0]));
  // R11: no write pulse outside the region leaves LED and page as they were
  assert_hold_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    !(wr_pulse && reg_hit) |=> ($stable(led) && $stable(page)));
endmodule

// File: rtl/membus_glue.sv
module membus_glue #(
  parameter int unsigned NUM_CE = 3,
  parameter int unsigned ADDR_W = 23,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned DISP_W = 6,
  parameter int unsigned LED_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CE-1:0] ce_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              aoe_n,
  input  logic              are_n,
  input  logic              awe_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              flash_ce_n,
  output logic              uart_a_cs_n,
  output logic              uart_b_cs_n,
  output logic              buf_oe_n,
  output logic              buf_dir,
  output logic [PAGE_W-1:0] flash_page,
  output logic [LED_W-1:0]  led,
  output logic [DATA_W-1:0] rdata
);
  import glue_pkg::*;

  logic reg_hit;
  logic wr_rise;
  logic rd_en;

  cs_decode #(.NUM_CE(NUM_CE), .ADDR_W(ADDR_W)) u_dec (
    .ce_n(ce_n), .addr(addr), .aoe_n(aoe_n),
    .flash_ce_n(flash_ce_n), .uart_a_cs_n(uart_a_cs_n), .uart_b_cs_n(uart_b_cs_n),
    .reg_hit(reg_hit), .buf_oe_n(buf_oe_n), .buf_dir(buf_dir)
  );

  strobe_edge u_wedge (.clk(clk), .rst(rst), .strobe_n(awe_n), .rise(wr_rise));

  assign rd_en = reg_hit && !are_n;

  ctrl_regs #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W), .LED_W(LED_W)) u_regs (
    .clk(clk), .rst(rst), .wr_pulse(wr_rise), .reg_hit(reg_hit),
    .idx(addr[IDX_W-1:0]), .wdata(wdata), .rd_en(rd_en),
    .page(flash_page), .led(led), .rdata(rdata)
  );

  // R9: read data stays zero outside a selected read
  assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (are_n || ce_n[0]) |-> rdata == '0);
  // R1: the flash is never selected in the upper half of the first space
  assert_flash_low_half_R1: assert property (@(posedge clk) disable iff (rst)
    !flash_ce_n |-> (!ce_n[0] && !addr[ADDR_W-1]));
endmodule

// File: tb/membus_glue_test.sv
`timescale 1ns/1ps
module membus_glue_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] ce_n;
  logic [22:0] addr;
  logic       aoe_n, are_n, awe_n;
  logic [7:0] wdata;
  logic       flash_ce_n, uart_a_cs_n, uart_b_cs_n, buf_oe_n, buf_dir;
  logic [2:0] flash_page;
  logic [7:0] led, rdata;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  membus_glue uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .addr(addr), .aoe_n(aoe_n),
    .are_n(are_n), .awe_n(awe_n), .wdata(wdata),
    .flash_ce_n(flash_ce_n), .uart_a_cs_n(uart_a_cs_n), .uart_b_cs_n(uart_b_cs_n),
    .buf_oe_n(buf_oe_n), .buf_dir(buf_dir), .flash_page(flash_page),
    .led(led), .rdata(rdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] reg_addr(input int idx);
    return (23'(1) << 22) | (23'(2) << 6) | 23'(idx);
  endfunction

  task automatic bus_write(input logic [2:0] ce, input logic [22:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = ce; addr = a; wdata = d; awe_n = 1'b0;
    @(negedge clk); awe_n = 1'b1;
    @(negedge clk); ce_n = 3'b111;
  endtask

  task automatic bus_read(input int idx, output logic [7:0] v);
    @(negedge clk); ce_n = 3'b110; addr = reg_addr(idx); are_n = 1'b0;
    #1 v = rdata;
    @(negedge clk); are_n = 1'b1; ce_n = 3'b111;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    rst = 1'b1; ce_n = 3'b111; addr = '0; aoe_n = 1'b1; are_n = 1'b1;
    awe_n = 1'b1; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 page after reset", flash_page, 0);
    chk("R10 led after reset", led, 0);
    bus_read(0, rv); chk("R10 disp after reset", rv, 0);

    // R1 R2 R3 R4 R9: exhaustive decode sweep
    for (int ce = 0; ce < 8; ce++)
      for (int hi = 0; hi < 2; hi++)
        for (int win = 0; win < 8; win++)
          for (int oe = 0; oe < 2; oe++) begin
            bit s1, any;
            @(negedge clk);
            ce_n = 3'(ce); addr = (23'(hi) << 22) | (23'(win) << 6) | 23'd5; aoe_n = oe[0];
            #1;
            s1  = (ce % 2) == 0;
            any = ce != 7;
            chk("R1 flash select", flash_ce_n, !(s1 && hi == 0));
            chk("R2 uart A select", uart_a_cs_n, !(s1 && hi == 1 && win == 0));
            chk("R2 uart B select", uart_b_cs_n, !(s1 && hi == 1 && win == 1));
            chk("R3 buffer enable", buf_oe_n, !any);
            chk("R4 buffer direction", buf_dir, any && oe == 0);
            chk("R9 idle rdata", rdata, 0);
          end
    @(negedge clk); ce_n = 3'b111;

    // R8: every LED value
    for (int v = 0; v < 256; v++) begin
      bus_write(3'b110, reg_addr(2), 8'(v));
      chk("R8 led drive", led, v);
      if (v % 37 == 0) begin bus_read(2, rv); chk("R8 led readback", rv, v); end
    end

    // R6: every page value with upper garbage
    for (int v = 0; v < 8; v++) begin
      bus_write(3'b110, reg_addr(1), 8'hF8 | 8'(v));
      chk("R6 page lines", flash_page, v);
      bus_read(1, rv); chk("R6 page readback", rv, v);
    end

    // R7
    bus_write(3'b110, reg_addr(0), 8'hFF);
    bus_read(0, rv); chk("R7 disp readback", rv, 8'h3F);
    bus_write(3'b110, reg_addr(0), 8'hA5);
    bus_read(0, rv); chk("R7 disp readback", rv, 8'h25);

    // R9: unused indices
    for (int i = 3; i < 8; i++) begin
      bus_write(3'b110, reg_addr(i), 8'hFF);
      bus_read(i, rv); chk("R9 unused index reads zero", rv, 0);
    end
    chk("R9 unused write leaves led", led, 8'hFF);
    chk("R9 unused write leaves page", flash_page, 7);
    bus_read(0, rv); chk("R9 unused write leaves disp", rv, 8'h25);

    // R9: selected but strobe idle
    @(negedge clk); ce_n = 3'b110; addr = reg_addr(2); are_n = 1'b1;
    #1 chk("R9 no strobe rdata", rdata, 0);
    @(negedge clk); ce_n = 3'b111;

    // R11: writes outside the region
    bus_write(3'b111, reg_addr(2), 8'h11);
    chk("R11 space inactive", led, 8'hFF);
    bus_write(3'b110, 23'h400000 | 23'd2, 8'h22);
    chk("R11 uart window", led, 8'hFF);
    bus_write(3'b110, 23'(2 << 6) | 23'd2, 8'h33);
    chk("R11 flash half", led, 8'hFF);

    // R5: strobe held low does nothing until release
    @(negedge clk); ce_n = 3'b110; addr = reg_addr(2); wdata = 8'h5A; awe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 held strobe no write", led, 8'hFF);
    awe_n = 1'b1;
    @(negedge clk);
    chk("R5 write on release", led, 8'h5A);
    ce_n = 3'b111;

    // R10: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 led cleared", led, 0);
    chk("R10 page cleared", flash_page, 0);
    bus_read(0, rv); chk("R10 disp cleared", rv, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule